// File: doc/BRIEF.md
# Masked Sticky Interrupt Combiner

This block gathers 512 interrupt sources into one interrupt output. Sources 0 to 255 are raised by participants on the attached serial bus. Sources 256 to 511 are raised by event logic inside the controller. Each source arrives as a one-cycle trigger pulse. The pulse sets a pending bit, and that bit stays set until software clears it. The pulse sets the bit even when the source is disabled. A separate enable bank selects which pending bits may drive the combined output. Both banks are organised as 32-bit words and sit behind a small register read/write port.

Four controller sources have fixed meanings: source 0 signals completion of a command that asked for notification, sources 6 and 11 signal a read with a failed parity check, and source 7 signals a missing acknowledge. Controller source 27 reports an attempt to take a word from an empty receive queue. This source behaves as a level: once it is raised it stays pending, and only reset clears it.

The register port has a two-state read machine. In PORT_IDLE no read data is presented. A read request in any state moves the machine to PORT_RESP, and it presents the data of that read for one cycle. Without a new read request, PORT_RESP returns to PORT_IDLE. A read request while in PORT_RESP keeps the machine in PORT_RESP.

Top module: `sticky_irq_combiner`

## Requirements
- R1: The enable bank occupies the word-aligned byte addresses 0x20 to 0x5C. Word k, at address 0x20+4k, holds the enables for sources 32k to 32k+31, with source 32k in bit 0. A bit value of 1 enables the source. A write stores the full word, and a read returns it.
- R2: The pending bank sits 0x40 above the enable bank, at 0x60 to 0x9C, with the same source-to-bit mapping. A read returns the pending bits.
- R3: A trigger pulse on a source makes its pending bit read 1 from the next cycle on, whatever the enable bit holds. A pending bit never becomes set without a trigger.
- R4: Writing a pending word clears every bit written as 1 and leaves every bit written as 0 unchanged. Such a write does not alter the enable bank.
- R5: irq_out is 1 exactly when at least one source has both its enable bit and its pending bit at 1. irq_out follows the bank contents with no added register stage.
- R6: bus_trig[i] drives source i, so the enable words are 0x20 to 0x3C and the pending words are 0x60 to 0x7C. ctrl_trig[j] drives source 256+j, so the enable words are 0x40 to 0x5C and the pending words are 0x80 to 0x9C. ctrl_trig[0] therefore appears as bit 0 of 0x80, and bus_trig[255] appears as bit 31 of 0x7C.
- R7: When a trigger and a write-1 clear hit the same pending bit in the same cycle, the bit ends up set.
- R8: Controller source 27, which is bit 27 of pending word 0x80, cannot be cleared by a write of 1. Once set, it stays set until reset.
- R9: Reset, active low on rst_n, sets every enable bit and every pending bit to 0. During reset irq_out and reg_rvalid are 0.
- R10: A read request (reg_en=1 with reg_wr=0) makes reg_rvalid 1 in the following cycle. In that cycle reg_rdata holds the addressed word as it stood at the request edge. Addresses outside 0x20 to 0x9F, or with bits [1:0] not 00, read as 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_trig | input | 256 | Trigger pulses from bus participants, one per source |
| ctrl_trig | input | 256 | Trigger pulses from controller events, one per source |
| reg_en | input | 1 | Register access request |
| reg_wr | input | 1 | 1 selects a write, 0 selects a read |
| reg_addr | input | 8 | Byte address of the accessed word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while reg_rvalid is 1 |
| reg_rvalid | output | 1 | Read data valid, one cycle after a read request |
| irq_out | output | 1 | Combined interrupt, OR over all sources of enable AND pending |

## Verification
The assertions assume that trigger vectors are synchronous to clk, are sampled only at rising edges, and are held at zero while reset is asserted. They also assume that reg_wr and reg_addr matter only in cycles where reg_en is 1. The stimulus changes every input at the falling clock edge and keeps the triggers quiet during reset. Random trigger bits, register writes and reads are mixed with directed cases for clear-versus-trigger collisions, the stuck underflow source, and addresses that fall outside the map or are misaligned.

// File: rtl/sic_pkg.sv
package sic_pkg;

    // State of the register read-response machine
    typedef enum logic {
        PORT_IDLE = 1'b0,
        PORT_RESP = 1'b1
    } port_state_e;

    // Default word width of both banks
    localparam int SIC_WORD_W = 32;

    // Controller source that is level-type and immune to write-1 clear
    localparam int SIC_UNDERFLOW_LINE = 27;

endpackage

// File: rtl/sic_decode.sv
module sic_decode #(
    parameter int ADDR_W    = 8,
    parameter int MASK_BASE = 32,
    parameter int NUM_WORDS = 16,
    localparam int IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_mask,
    output logic              hit_pend,
    output logic [IDX_W-1:0]  idx
);

    localparam int BASE_WORD = MASK_BASE / 4;

    always_comb begin
        int word_addr;
        int rel;
        logic aligned;
        word_addr = int'(addr[ADDR_W-1:2]);
        rel       = word_addr - BASE_WORD;
        aligned   = (addr[1:0] == 2'b00);
        hit_mask  = aligned && (rel >= 0) && (rel < NUM_WORDS);
        hit_pend  = aligned && (rel >= NUM_WORDS) && (rel < 2 * NUM_WORDS);
        if (hit_pend) begin
            idx = IDX_W'(rel - NUM_WORDS);
        end else begin
            idx = IDX_W'(rel);
        end
    end

endmodule

// File: rtl/sic_word.sv
module sic_word #(
    parameter int                DATA_W = 32,
    parameter logic [DATA_W-1:0] STICKY = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_we,
    input  logic              pend_wc,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] trig,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] pend_q,
    output logic              active
);

    logic [DATA_W-1:0] clr_bits;
    logic [DATA_W-1:0] pend_d;

    always_comb begin
        clr_bits = pend_wc ? (wdata & ~STICKY) : '0;
        // a trigger in the same cycle wins over a clear
        pend_d   = (pend_q & ~clr_bits) | trig;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            pend_q <= '0;
        end else begin
            if (mask_we) begin
                mask_q <= wdata;
            end
            pend_q <= pend_d;
        end
    end

    assign active = |(mask_q & pend_q);

endmodule

// File: rtl/sic_port.sv
module sic_port
    import sic_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    port_state_e state_q;
    port_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PORT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PORT_IDLE: if (rd_req) state_d = PORT_RESP;
            PORT_RESP: state_d = rd_req ? PORT_RESP : PORT_IDLE;
            default:   state_d = PORT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_req) begin
            rdata <= rd_word;
        end
    end

    always_comb begin
        rvalid = (state_q == PORT_RESP);
    end

endmodule

// File: rtl/sticky_irq_combiner.sv
module sticky_irq_combiner
    import sic_pkg::*;
#(
    parameter int BUS_LINES    = 256,
    parameter int CTRL_LINES   = 256,
    parameter int DATA_W       = SIC_WORD_W,
    parameter int ADDR_W       = 8,
    parameter int MASK_BASE    = 32,
    parameter int UF_CTRL_LINE = SIC_UNDERFLOW_LINE
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [BUS_LINES-1:0]  bus_trig,
    input  logic [CTRL_LINES-1:0] ctrl_trig,
    input  logic                  reg_en,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic                  reg_rvalid,
    output logic                  irq_out
);

    localparam int NUM_LINES = BUS_LINES + CTRL_LINES;
    localparam int NUM_WORDS = NUM_LINES / DATA_W;
    localparam int IDX_W     = $clog2(NUM_WORDS);
    localparam int UF_IDX    = BUS_LINES + UF_CTRL_LINE;
    localparam int UF_WORD   = UF_IDX / DATA_W;
    localparam int UF_BIT    = UF_IDX % DATA_W;

    logic [NUM_LINES-1:0]               trig_all;
    logic [NUM_WORDS-1:0][DATA_W-1:0]   mask_words;
    logic [NUM_WORDS-1:0][DATA_W-1:0]   pend_words;
    logic [NUM_LINES-1:0]               mask_all;
    logic [NUM_LINES-1:0]               pend_all;
    logic [NUM_WORDS-1:0]               word_active;
    logic                               hit_mask;
    logic                               hit_pend;
    logic [IDX_W-1:0]                   idx;
    logic                               wr_req;
    logic                               rd_req;
    logic [DATA_W-1:0]                  rd_word;

    assign trig_all = {ctrl_trig, bus_trig};
    assign mask_all = mask_words;
    assign pend_all = pend_words;
    assign wr_req   = reg_en && reg_wr;
    assign rd_req   = reg_en && !reg_wr;

    sic_decode #(
        .ADDR_W    (ADDR_W),
        .MASK_BASE (MASK_BASE),
        .NUM_WORDS (NUM_WORDS)
    ) u_decode (
        .addr     (reg_addr),
        .hit_mask (hit_mask),
        .hit_pend (hit_pend),
        .idx      (idx)
    );

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        localparam logic [DATA_W-1:0] STICKY_BITS =
            (w == UF_WORD) ? (DATA_W'(1) << UF_BIT) : '0;
        logic mask_we;
        logic pend_wc;
        assign mask_we = wr_req && hit_mask && (idx == IDX_W'(w));
        assign pend_wc = wr_req && hit_pend && (idx == IDX_W'(w));

        sic_word #(
            .DATA_W (DATA_W),
            .STICKY (STICKY_BITS)
        ) u_word (
            .clk     (clk),
            .rst_n   (rst_n),
            .mask_we (mask_we),
            .pend_wc (pend_wc),
            .wdata   (reg_wdata),
            .trig    (trig_all[w*DATA_W +: DATA_W]),
            .mask_q  (mask_words[w]),
            .pend_q  (pend_words[w]),
            .active  (word_active[w])
        );
    end

    always_comb begin
        rd_word = '0;
        if (hit_mask) begin
            rd_word = mask_words[idx];
        end else if (hit_pend) begin
            rd_word = pend_words[idx];
        end
    end

    sic_port #(
        .DATA_W (DATA_W)
    ) u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_req  (rd_req),
        .rd_word (rd_word),
        .rdata   (reg_rdata),
        .rvalid  (reg_rvalid)
    );

    assign irq_out = |word_active;

endmodule

// File: rtl/sticky_irq_combiner_chk.sv
module sticky_irq_combiner_chk #(
    parameter int NUM_LINES = 512,
    parameter int UF_IDX    = 283
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] trig_all,
    input logic [NUM_LINES-1:0] mask_all,
    input logic [NUM_LINES-1:0] pend_all,
    input logic                 reg_en,
    input logic                 reg_wr,
    input logic                 reg_rvalid,
    input logic                 irq_out
);

    // R3: every triggered source is pending one cycle later
    p_set_on_trigger_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_all & $past(trig_all)) == $past(trig_all)));

    // R3: a pending bit rises only with a trigger
    p_no_spurious_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_all & ~$past(pend_all) & ~$past(trig_all)) == '0));

    // R5: the combined output reflects enable AND pending
    p_irq_combine_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (|(mask_all & pend_all)));

    // R1: the enable bank changes only on a register write
    p_mask_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_en && reg_wr) |=> $stable(mask_all));

    // R8: the underflow source never drops once set
    p_underflow_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pend_all[UF_IDX] |=> pend_all[UF_IDX]);

    // R10: a read request yields valid data in the next cycle
    p_rvalid_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && !reg_wr) |=> reg_rvalid);

    // R10: no valid data without a preceding read request
    p_rvalid_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_en && !reg_wr) |=> !reg_rvalid);

endmodule

bind sticky_irq_combiner sticky_irq_combiner_chk #(
    .NUM_LINES (NUM_LINES),
    .UF_IDX    (UF_IDX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_all   (trig_all),
    .mask_all   (mask_all),
    .pend_all   (pend_all),
    .reg_en     (reg_en),
    .reg_wr     (reg_wr),
    .reg_rvalid (reg_rvalid),
    .irq_out    (irq_out)
);

// File: tb/sticky_irq_combiner_tb.sv
`timescale 1ns/1ps
module sticky_irq_combiner_tb;

    localparam int NL      = 512;
    localparam int UF_LINE = 256 + 27;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [255:0] bus_trig;
    logic [255:0] ctrl_trig;
    logic         reg_en;
    logic         reg_wr;
    logic [7:0]   reg_addr;
    logic [31:0]  reg_wdata;
    logic [31:0]  reg_rdata;
    logic         reg_rvalid;
    logic         irq_out;

    int checks = 0;
    int fails  = 0;
    logic [NL-1:0] m_mask;
    logic [NL-1:0] m_pend;

    always #2.5 clk = ~clk;

    sticky_irq_combiner u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_trig   (bus_trig),
        .ctrl_trig  (ctrl_trig),
        .reg_en     (reg_en),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .reg_rvalid (reg_rvalid),
        .irq_out    (irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rd_exp(input logic [7:0] a);
        int w;
        w = int'(a[7:2]) - 8;
        if (a[1:0] != 2'b00) return 32'h0;
        if (w >= 0 && w < 16) return m_mask[w*32 +: 32];
        if (w >= 16 && w < 32) return m_pend[(w-16)*32 +: 32];
        return 32'h0;
    endfunction

    function automatic string rd_tag(input logic [7:0] a);
        if (a[1:0] != 2'b00) return "R10 unaligned";
        if (a >= 8'h20 && a < 8'h60) return "R1 enable read";
        if (a >= 8'h60 && a < 8'hA0) return "R2 pending read";
        return "R10 unmapped";
    endfunction

    task automatic cycle(input logic [255:0] bt, input logic [255:0] ct,
                         input logic en, input logic wr,
                         input logic [7:0] a, input logic [31:0] d);
        logic [NL-1:0] nxt_mask;
        logic [NL-1:0] clr;
        logic [31:0]   exp_rd;
        logic          is_rd;
        int            w;
        @(negedge clk);
        bus_trig  = bt;
        ctrl_trig = ct;
        reg_en    = en;
        reg_wr    = wr;
        reg_addr  = a;
        reg_wdata = d;
        is_rd  = en && !wr;
        exp_rd = rd_exp(a);
        nxt_mask = m_mask;
        clr      = '0;
        w = int'(a[7:2]) - 8;
        if (en && wr && a[1:0] == 2'b00) begin
            if (w >= 0 && w < 16) nxt_mask[w*32 +: 32] = d;
            if (w >= 16 && w < 32) clr[(w-16)*32 +: 32] = d;
        end
        clr[UF_LINE] = 1'b0;
        @(posedge clk);
        m_mask = nxt_mask;
        m_pend = (m_pend & ~clr) | {ct, bt};
        #1;
        chk("R5 irq_out", {31'b0, irq_out}, {31'b0, |(m_mask & m_pend)});
        chk("R10 rvalid", {31'b0, reg_rvalid}, {31'b0, is_rd});
        if (is_rd) chk(rd_tag(a), reg_rdata, exp_rd);
    endtask

    task automatic idle();
        cycle('0, '0, 1'b0, 1'b0, 8'h0, 32'h0);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cycle('0, '0, 1'b1, 1'b1, a, d);
    endtask

    task automatic rd(input logic [7:0] a, input string tag, input logic [31:0] exp);
        cycle('0, '0, 1'b1, 1'b0, a, 32'h0);
        chk(tag, reg_rdata, exp);
    endtask

    task automatic main_seq();
        logic [255:0] bt;
        logic [255:0] ct;
        int seed;
        rst_n = 1'b0;
        bus_trig = '0; ctrl_trig = '0;
        reg_en = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        m_mask = '0; m_pend = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R9 irq in reset", {31'b0, irq_out}, 32'h0);
        chk("R9 rvalid in reset", {31'b0, reg_rvalid}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 32; k++) rd(8'(8'h20 + 4*k), "R9 reset word", 32'h0);

        // R3: masked source still latches
        bt = '0; bt[5] = 1'b1;
        cycle(bt, '0, 1'b0, 1'b0, 8'h0, 32'h0);
        rd(8'h60, "R3 masked latch", 32'h20);
        chk("R5 masked no irq", {31'b0, irq_out}, 32'h0);
        wr(8'h20, 32'h20);
        chk("R5 enabled irq", {31'b0, irq_out}, 32'h1);
        // R4: zero bits leave pending alone, one bits clear
        wr(8'h60, 32'h0);
        rd(8'h60, "R4 write zero no effect", 32'h20);
        wr(8'h60, 32'hFFFF_FFFF);
        rd(8'h60, "R4 write one clears", 32'h0);
        chk("R5 irq drops", {31'b0, irq_out}, 32'h0);
        rd(8'h20, "R4 enable untouched", 32'h20);

        // R6: source mapping at the bank edges
        bt = '0; bt[255] = 1'b1;
        ct = '0; ct[0] = 1'b1;
        cycle(bt, ct, 1'b0, 1'b0, 8'h0, 32'h0);
        rd(8'h7C, "R6 bus line 255", 32'h8000_0000);
        rd(8'h80, "R6 ctrl line 0", 32'h0000_0001);

        // R7: trigger beats clear in the same cycle
        ct = '0; ct[7] = 1'b1;
        cycle('0, ct, 1'b1, 1'b1, 8'h80, 32'h0000_0081);
        rd(8'h80, "R7 trigger wins", 32'h0000_0080);

        // R8: underflow source ignores write-1 clear
        ct = '0; ct[27] = 1'b1;
        cycle('0, ct, 1'b0, 1'b0, 8'h0, 32'h0);
        wr(8'h80, 32'hFFFF_FFFF);
        rd(8'h80, "R8 underflow stays", 32'h0800_0000);
        wr(8'h40, 32'h0800_0000);
        wr(8'h80, 32'hFFFF_FFFF);
        chk("R8 irq held by underflow", {31'b0, irq_out}, 32'h1);
        wr(8'h40, 32'h0);

        // R10: out-of-map and misaligned accesses
        wr(8'hA0, 32'hFFFF_FFFF);
        wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'h22, 32'hFFFF_FFFF);
        rd(8'hA0, "R10 above map reads zero", 32'h0);
        rd(8'h1C, "R10 below map reads zero", 32'h0);
        rd(8'h22, "R10 unaligned reads zero", 32'h0);
        rd(8'h20, "R10 stray write ignored", 32'h20);
        rd(8'h40, "R10 stray write ignored", 32'h0);

        // constrained random phase
        seed = $urandom(32'h5EED_0007);
        for (int n = 0; n < 3000; n++) begin
            int op;
            bt = '0;
            ct = '0;
            if ($urandom_range(3) == 0) bt[$urandom_range(255)] = 1'b1;
            if ($urandom_range(3) == 0) ct[$urandom_range(255)] = 1'b1;
            if ($urandom_range(15) == 0) ct[$urandom_range(31)] = 1'b1;
            op = int'($urandom_range(3));
            case (op)
                0: cycle(bt, ct, 1'b0, 1'b0, 8'h0, 32'h0);
                1: cycle(bt, ct, 1'b1, 1'b1, 8'(8'h20 + 4*$urandom_range(15)),
                         $urandom() & $urandom());
                2: cycle(bt, ct, 1'b1, 1'b1, 8'(8'h60 + 4*$urandom_range(15)), $urandom());
                default: cycle(bt, ct, 1'b1, 1'b0, 8'($urandom_range(255)), 32'h0);
            endcase
        end
        for (int k = 0; k < 32; k++) begin
            logic [7:0] a;
            a = 8'(8'h20 + 4*k);
            rd(a, rd_tag(a), rd_exp(a));
        end
        idle();
        if (seed == 0) idle();
    endtask

    initial begin
        fork
            main_seq();
            begin
                repeat (150000) @(posedge clk);
                fails++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule